// File: doc/BRIEF.md
# Four-phase handshake read over a shared address/data bus

This block carries one read at a time between a master controller and a slave controller. The two sides share one set of address/data lines and four control lines. Neither side assumes anything about when the other will respond. Each side moves only after it sees the other side's control edge, and every such edge first passes through a two-flop synchronizer. Driver ownership of the shared lines is modelled as two output enables, and the bus resolves to the enabled driver or to zero.

A read takes two interlocked handshakes. In the first, the master raises its request with the address on the shared lines. The slave captures the address and raises its acknowledge. The master then releases the request and the lines, and the slave drops its acknowledge. In the second, after a programmable access wait, the slave drives the word and raises data-ready. The master latches the word and raises its own acknowledge. The slave then releases the lines and lowers data-ready, and the master lowers its acknowledge to finish.

The user side is a start/busy/done interface with a held read-data output. The slave holds a fixed memory array filled at reset.

Top module: `hs_read_bus`

## Requirements
- R1: During and right after reset: busy, done, read data, all four control lines, both enables and the bus are zero.
- R2: A start sampled while idle raises busy, the request line and the master enable one cycle later, with the address on the bus.
- R3: The slave acknowledge rises 3 cycles after the request rises (two synchronizer flops plus the state register).
- R4: The master releases the request and its enable 3 cycles after the slave acknowledge rises.
- R5: The slave acknowledge falls 3 cycles after the request falls.
- R6: Data-ready and the slave enable rise WAIT+1 cycles after the slave acknowledge falls, where WAIT is the access-wait input (0 to 15).
- R7: The master acknowledge rises 3 cycles after data-ready rises, and read data then holds the word on the bus.
- R8: Data-ready and the slave enable fall 3 cycles after the master acknowledge rises.
- R9: The master acknowledge falls 3 cycles after data-ready falls. Done pulses for exactly that one cycle and busy is low in it, so a read takes WAIT+19 cycles from start to done.
- R10: The master enable and the slave enable are never high together.
- R11: A start while busy is ignored. It neither changes the returned word nor begins a second read. A start held high is taken again on the cycle after done.
- R12: The slave word at address a is (a*37+11) mod 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a read when idle |
| addr | input | W | Read address, taken with start |
| access_wait | input | CW | Slave access wait in cycles |
| busy | output | 1 | Read in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | W | Last word read |
| bus_ad | output | W | Resolved shared address/data lines |
| bus_req | output | 1 | Master read request |
| bus_sack | output | 1 | Slave acknowledge |
| bus_drdy | output | 1 | Slave data-ready |
| bus_mack | output | 1 | Master acknowledge |
| m_oe | output | 1 | Master drives the shared lines |
| s_oe | output | 1 | Slave drives the shared lines |

## Verification
The assertions check the ordering of the handshake on every cycle. Each control edge may occur only in the state of the opposite line that the protocol allows. The two enables never overlap, and done is a single-cycle pulse that comes with the master's final release. Only the bench's scenarios can show the exact cycle counts through the synchronizers, the effect of the access wait, the returned words at the extreme addresses, and that a start during a read or a start held high is handled as required.

// File: rtl/hs_read_bus.sv
module hs_read_bus #(
  parameter int W  = 8,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [W-1:0]  addr,
  input  logic [CW-1:0] access_wait,
  output logic          busy,
  output logic          done,
  output logic [W-1:0]  rdata,
  output logic [W-1:0]  bus_ad,
  output logic          bus_req,
  output logic          bus_sack,
  output logic          bus_drdy,
  output logic          bus_mack,
  output logic          m_oe,
  output logic          s_oe
);
  localparam int DEPTH = 1 << W;

  typedef enum logic [1:0] {M_IDLE, M_REQ, M_WAITD, M_ACK} mst_t;
  typedef enum logic [2:0] {S_IDLE, S_ACK, S_WAIT, S_DATA, S_FIN} slv_t;

  mst_t          mst;
  slv_t          slv;
  logic [W-1:0]  m_addr, s_addr, s_word;
  logic [CW-1:0] cnt;
  logic [1:0]    req_sy, sack_sy, drdy_sy, mack_sy;
  logic [W-1:0]  mem [DEPTH];

  assign bus_req  = (mst == M_REQ);
  assign m_oe     = (mst == M_REQ);
  assign bus_mack = (mst == M_ACK);
  assign busy     = (mst != M_IDLE);
  assign bus_sack = (slv == S_ACK);
  assign bus_drdy = (slv == S_DATA);
  assign s_oe     = (slv == S_DATA);
  assign bus_ad   = m_oe ? m_addr : (s_oe ? s_word : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_sy  <= '0;
      sack_sy <= '0;
      drdy_sy <= '0;
      mack_sy <= '0;
    end else begin
      req_sy  <= {req_sy[0],  bus_req};
      sack_sy <= {sack_sy[0], bus_sack};
      drdy_sy <= {drdy_sy[0], bus_drdy};
      mack_sy <= {mack_sy[0], bus_mack};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mst    <= M_IDLE;
      m_addr <= '0;
      rdata  <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (mst)
        M_IDLE:  if (start) begin
                   m_addr <= addr;
                   mst    <= M_REQ;
                 end
        M_REQ:   if (sack_sy[1]) mst <= M_WAITD;
        M_WAITD: if (drdy_sy[1]) begin
                   rdata <= bus_ad;
                   mst   <= M_ACK;
                 end
        M_ACK:   if (!drdy_sy[1]) begin
                   mst  <= M_IDLE;
                   done <= 1'b1;
                 end
        default: mst <= M_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= W'(i * 37 + 11);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slv    <= S_IDLE;
      s_addr <= '0;
      s_word <= '0;
      cnt    <= '0;
    end else begin
      case (slv)
        S_IDLE: if (req_sy[1]) begin
                  s_addr <= bus_ad;
                  slv    <= S_ACK;
                end
        S_ACK:  if (!req_sy[1]) begin
                  cnt <= '0;
                  slv <= S_WAIT;
                end
        S_WAIT: if (cnt == access_wait) begin
                  s_word <= mem[s_addr];
                  slv    <= S_DATA;
                end else begin
                  cnt <= cnt + 1'b1;
                end
        S_DATA: if (mack_sy[1]) slv <= S_FIN;
        S_FIN:  if (!mack_sy[1]) slv <= S_IDLE;
        default: slv <= S_IDLE;
      endcase
    end
  end
endmodule

module hs_read_bus_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic bus_req,
  input logic bus_sack,
  input logic bus_drdy,
  input logic bus_mack,
  input logic m_oe,
  input logic s_oe
);
  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n) !(m_oe && s_oe)); // R10
  AST_SACK_RISE: assert property (@(posedge clk) disable iff (!rst_n) $rose(bus_sack) |-> bus_req); // R3
  AST_REQ_FALL: assert property (@(posedge clk) disable iff (!rst_n) $fell(bus_req) |-> bus_sack && !m_oe); // R4
  AST_SACK_FALL: assert property (@(posedge clk) disable iff (!rst_n) $fell(bus_sack) |-> !bus_req); // R5
  AST_DRDY_RISE: assert property (@(posedge clk) disable iff (!rst_n) $rose(bus_drdy) |-> !bus_req && !bus_sack && !bus_mack); // R6
  AST_MACK_RISE: assert property (@(posedge clk) disable iff (!rst_n) $rose(bus_mack) |-> bus_drdy); // R7
  AST_DRDY_FALL: assert property (@(posedge clk) disable iff (!rst_n) $fell(bus_drdy) |-> bus_mack && !s_oe); // R8
  AST_MACK_FALL: assert property (@(posedge clk) disable iff (!rst_n) $fell(bus_mack) |-> !bus_drdy && done); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R9
endmodule

bind hs_read_bus hs_read_bus_chk chk_i (.*);

// File: tb/hs_read_bus_tb_top.sv
module hs_read_bus_tb_top;
  localparam int W = 8;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] addr = '0;
  logic [CW-1:0] access_wait = '0;
  logic busy, done, bus_req, bus_sack, bus_drdy, bus_mack, m_oe, s_oe;
  logic [W-1:0] rdata, bus_ad;

  int errs = 0;
  int checks = 0;
  int cycles = 0;
  bit finished = 0;

  bit active = 0;
  int n = 0;
  int ew = 0;
  logic [W-1:0] ea = '0;
  logic [W-1:0] exp_rdata = '0;

  hs_read_bus #(.W(W), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .addr(addr), .access_wait(access_wait),
    .busy(busy), .done(done), .rdata(rdata), .bus_ad(bus_ad),
    .bus_req(bus_req), .bus_sack(bus_sack), .bus_drdy(bus_drdy), .bus_mack(bus_mack),
    .m_oe(m_oe), .s_oe(s_oe)
  );

  always #10 clk = ~clk;

  function automatic logic [W-1:0] memf(input logic [W-1:0] a);
    return W'(int'(a) * 37 + 11);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      active = 0;
      exp_rdata = '0;
    end else begin
      if (active) begin
        n++;
        if (n == 13 + ew) exp_rdata = memf(ea);
        if (n == 20 + ew) active = 0;
      end
      if (!active && start) begin
        active = 1;
        n = 0;
        ea = addr;
        ew = int'(access_wait);
      end
    end
    if (cycles > 100000 && !finished) begin
      errs++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  always @(negedge clk) begin
    logic ereq, esack, edrdy, emack, edone, ebusy;
    logic [W-1:0] ebus;
    ereq  = active && n <= 5;
    esack = active && n >= 3 && n <= 8;
    edrdy = active && n >= 10 + ew && n <= 15 + ew;
    emack = active && n >= 13 + ew && n <= 18 + ew;
    edone = active && n == 19 + ew;
    ebusy = active && n <= 18 + ew;
    ebus  = ereq ? ea : (edrdy ? memf(ea) : '0);
    chk("R2/R4 request", 32'(bus_req), 32'(ereq));
    chk("R2/R4 master enable", 32'(m_oe), 32'(ereq));
    chk("R3/R5 slave ack", 32'(bus_sack), 32'(esack));
    chk("R6/R8 data-ready", 32'(bus_drdy), 32'(edrdy));
    chk("R6/R8 slave enable", 32'(s_oe), 32'(edrdy));
    chk("R7/R9 master ack", 32'(bus_mack), 32'(emack));
    chk("R9 done", 32'(done), 32'(edone));
    chk("R11 busy", 32'(busy), 32'(ebusy));
    chk("R7 rdata", 32'(rdata), 32'(exp_rdata));
    chk("R12 bus", 32'(bus_ad), 32'(ebus));
    chk("R10 overlap", 32'(m_oe && s_oe), 32'(0));
  end

  task automatic wait_done(input int limit);
    for (int k = 0; k < limit; k++) begin
      @(negedge clk);
      if (done) return;
    end
    errs++;
    $display("FAIL R9 done never seen");
  endtask

  task automatic read_once(input logic [W-1:0] a, input int w);
    @(negedge clk);
    addr = a;
    access_wait = CW'(w);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 busy after start", 32'(busy), 32'(1));
    wait_done(60);
    chk("R12 word returned", 32'(rdata), 32'(memf(a)));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset busy", 32'(busy), 32'(0));
    chk("R1 reset bus", 32'(bus_ad), 32'(0));
    chk("R1 reset lines", 32'({bus_req, bus_sack, bus_drdy, bus_mack, m_oe, s_oe, done}), 32'(0));
    chk("R1 reset rdata", 32'(rdata), 32'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", 32'(busy), 32'(0));

    read_once(8'h00, 0);
    read_once(8'hFF, 15);
    read_once(8'h5A, 3);

    @(negedge clk);
    addr = 8'h21;
    access_wait = 4'd2;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    addr = 8'h99;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(60);
    chk("R11 word unchanged by late start", 32'(rdata), 32'(memf(8'h21)));
    repeat (25) @(negedge clk);
    chk("R11 no second read", 32'(busy), 32'(0));

    addr = 8'h10;
    access_wait = 4'd1;
    start = 1'b1;
    wait_done(60);
    chk("R12 first of pair", 32'(rdata), 32'(memf(8'h10)));
    addr = 8'hC3;
    @(negedge clk);
    start = 1'b0;
    chk("R11 held start taken again", 32'(busy), 32'(1));
    wait_done(60);
    chk("R12 second of pair", 32'(rdata), 32'(memf(8'hC3)));

    repeat (5) @(negedge clk);
    finished = 1;
    summary();
  end
endmodule